// File: doc/BRIEF.md
# Two-Stage ALU and Shifter Datapath

This block is a purely combinational datapath slice for a small microcoded engine. The control word supplies two operands and two 3-bit codes. The first stage is an arithmetic/logic unit. It applies one of eight fixed operations to the operands. Its result goes straight into a one-position shifter stage. That stage can pass the value, rotate it, or shift it with a chosen fill bit. The shifter output is the block's result. A zero flag is also raised whenever that final result is all zeros.

The block holds no state, so every output is a function of the present inputs only. The surrounding sequencer owns microinstruction decoding, register selection and the writeback timing. The operand width is a parameter with a default of 8. All arithmetic wraps modulo 2^WIDTH, and no carry is brought out. A second parameter picks how the adder is built: an explicit ripple chain or a plain `+` that synthesis maps.

Top module: `mcalu_top`

## Requirements
- R1: ALU code 3'b000 yields the bitwise inverse of operand A; operand B has no effect.
- R2: ALU codes 3'b001, 3'b010 and 3'b011 yield A AND B, A XOR B and A OR B respectively.
- R3: ALU code 3'b100 yields A+1 and code 3'b110 yields A−1, both modulo 2^WIDTH (0xFF+1 gives 0x00 and 0x00−1 gives 0xFF at WIDTH 8); operand B has no effect.
- R4: ALU code 3'b101 yields A+B and code 3'b111 yields A−B, both modulo 2^WIDTH with no carry or borrow output.
- R5: Shift codes 3'b000 and 3'b100 both pass the ALU result to the output unchanged.
- R6: Shift code 3'b001 rotates the ALU result left by one (the MSB enters bit 0), and code 3'b101 rotates it right by one (bit 0 enters the MSB).
- R7: Shift codes 3'b010 and 3'b011 shift the ALU result left by one, with 0 or 1 respectively placed into bit 0.
- R8: Shift codes 3'b110 and 3'b111 shift the ALU result right by one, with 0 or 1 respectively placed into the MSB.
- R9: The zero flag is 1 exactly when the final shifter output is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | Operand A |
| opb_i | input | WIDTH | Operand B |
| alu_code_i | input | 3 | ALU operation select |
| shf_code_i | input | 3 | Shifter operation select |
| result_o | output | WIDTH | Shifter output (final result) |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
Both results are due in the cycle the inputs are applied. The block has no register anywhere, so the latency is zero cycles for `result_o` and for `zero_o`. The driver changes inputs shortly after a rising edge and queues the expected pair. The monitor compares on the following falling edge, which gives the combinational paths half a period to settle. There is never more than one item outstanding, and the queue must be empty at the end. All 64 pairings of ALU code and shift code are run. Each pairing uses directed operands that force wrap-around and all-zero results, plus random operands.

// File: rtl/mcalu_pkg.sv
package mcalu_pkg;

   localparam int CODE_W = 3;

   typedef enum logic [CODE_W-1:0] {
      ALU_INV = 3'b000,
      ALU_AND = 3'b001,
      ALU_XOR = 3'b010,
      ALU_OR  = 3'b011,
      ALU_INC = 3'b100,
      ALU_ADD = 3'b101,
      ALU_DEC = 3'b110,
      ALU_SUB = 3'b111
   } alu_code_e;

   // low two bits of the shift code: what moves in, if anything
   typedef enum logic [1:0] {
      SHK_PASS  = 2'b00,
      SHK_ROT   = 2'b01,
      SHK_FILL0 = 2'b10,
      SHK_FILL1 = 2'b11
   } shf_kind_e;

   // bit 2 of the shift code: direction
   localparam logic SHD_LEFT  = 1'b0;
   localparam logic SHD_RIGHT = 1'b1;

endpackage

// File: rtl/mcalu_logic.sv
module mcalu_logic #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [1:0]       sel_i,
   output logic [WIDTH-1:0] y_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("mcalu_logic: WIDTH must be at least 1");
   end

   always_comb begin
      unique case (sel_i)
         2'b00:   y_o = ~a_i;
         2'b01:   y_o = a_i & b_i;
         2'b10:   y_o = a_i ^ b_i;
         default: y_o = a_i | b_i;
      endcase
   end

   always_comb begin
      if (sel_i == 2'b00) begin
         AST_INV_DISJOINT: assert (((y_o & a_i) == '0) && ((y_o | a_i) == '1)); // R1
      end
      if (sel_i == 2'b01) begin
         AST_AND_SUBSET: assert (((y_o & ~a_i) == '0) && ((y_o & ~b_i) == '0)); // R2
      end
      if (sel_i == 2'b10) begin
         AST_XOR_INVERT: assert ((y_o ^ b_i) == a_i); // R2
      end
      if (sel_i == 2'b11) begin
         AST_OR_COVER: assert (((a_i & ~y_o) == '0) && ((b_i & ~y_o) == '0)); // R2
      end
   end
endmodule

// File: rtl/mcalu_arith.sv
module mcalu_arith #(
   parameter int WIDTH        = 8,
   parameter bit RIPPLE_ADDER = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             use_b_i,   // 1: second operand is B, 0: constant one
   input  logic             negate_i,  // 1: subtract instead of add
   output logic [WIDTH-1:0] y_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("mcalu_arith: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] addend;
   logic             carry_in;

   // One adder serves all four codes:
   //   inc: a + 0 + 1     dec: a + ~0 + 0
   //   add: a + b + 0     sub: a + ~b + 1
   assign addend   = (use_b_i ? b_i : '0) ^ {WIDTH{negate_i}};
   assign carry_in = ~(negate_i ^ use_b_i);

   if (RIPPLE_ADDER) begin : g_ripple
      logic [WIDTH:0] carry;
      assign carry[0] = carry_in;
      for (genvar i = 0; i < WIDTH; i++) begin : g_fa
         assign y_o[i]     = a_i[i] ^ addend[i] ^ carry[i];
         assign carry[i+1] = (a_i[i] & addend[i]) | (carry[i] & (a_i[i] ^ addend[i]));
      end
   end else begin : g_behav
      logic [WIDTH:0] sum_ext;
      assign sum_ext = {1'b0, a_i} + {1'b0, addend} + {{WIDTH{1'b0}}, carry_in};
      assign y_o     = sum_ext[WIDTH-1:0];
   end

   // inverse relations: result minus A (or A minus result) recovers the step
   logic [WIDTH-1:0] step;
   logic [WIDTH-1:0] up_delta;
   logic [WIDTH-1:0] down_delta;
   assign step       = use_b_i ? b_i : WIDTH'(1);
   assign up_delta   = y_o - a_i;
   assign down_delta = a_i - y_o;

   always_comb begin
      if (!negate_i && !use_b_i) begin
         AST_INC_WRAP: assert (up_delta == step); // R3
      end
      if (negate_i && !use_b_i) begin
         AST_DEC_WRAP: assert (down_delta == step); // R3
      end
      if (!negate_i && use_b_i) begin
         AST_ADD_WRAP: assert (up_delta == step); // R4
      end
      if (negate_i && use_b_i) begin
         AST_SUB_WRAP: assert (down_delta == step); // R4
      end
   end
endmodule

// File: rtl/mcalu_shift.sv
module mcalu_shift
   import mcalu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0]  x_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [WIDTH-1:0]  y_o
);
   if (WIDTH < 2) begin : g_bad_width
      $error("mcalu_shift: WIDTH must be at least 2");
   end

   shf_kind_e kind;
   logic      dir;
   logic      in_bit;

   assign kind = shf_kind_e'(code_i[1:0]);
   assign dir  = code_i[2];

   always_comb begin
      if (kind == SHK_ROT) begin
         in_bit = (dir == SHD_RIGHT) ? x_i[0] : x_i[WIDTH-1];
      end else begin
         in_bit = code_i[0];
      end
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic from_lo;
      logic from_hi;
      if (i == 0) begin : g_lsb
         assign from_lo = in_bit;
      end else begin : g_mid_lo
         assign from_lo = x_i[i-1];
      end
      if (i == WIDTH-1) begin : g_msb
         assign from_hi = in_bit;
      end else begin : g_mid_hi
         assign from_hi = x_i[i+1];
      end
      assign y_o[i] = (kind == SHK_PASS)  ? x_i[i]  :
                      (dir == SHD_RIGHT)  ? from_hi : from_lo;
   end

   always_comb begin
      if (kind == SHK_PASS) begin
         AST_PASS_ALIAS: assert (y_o == x_i); // R5
      end
      if (kind == SHK_ROT) begin
         AST_ROT_KEEPS_ONES: assert ($countones(y_o) == $countones(x_i)); // R6
      end
      if (kind[1] && dir == SHD_LEFT) begin
         AST_LEFT_FILL: assert ((y_o[0] == code_i[0]) && (y_o[WIDTH-1:1] == x_i[WIDTH-2:0])); // R7
      end
      if (kind[1] && dir == SHD_RIGHT) begin
         AST_RIGHT_FILL: assert ((y_o[WIDTH-1] == code_i[0]) && (y_o[WIDTH-2:0] == x_i[WIDTH-1:1])); // R8
      end
   end
endmodule

// File: rtl/mcalu_top.sv
module mcalu_top
   import mcalu_pkg::*;
#(
   parameter int WIDTH        = 8,
   parameter bit RIPPLE_ADDER = 1'b1
) (
   input  logic [WIDTH-1:0]  opa_i,
   input  logic [WIDTH-1:0]  opb_i,
   input  logic [CODE_W-1:0] alu_code_i,
   input  logic [CODE_W-1:0] shf_code_i,
   output logic [WIDTH-1:0]  result_o,
   output logic              zero_o
);
   if (WIDTH < 2) begin : g_bad_width
      $error("mcalu_top: WIDTH must be at least 2");
   end
   if (CODE_W != 3) begin : g_bad_code
      $error("mcalu_top: operation codes must be 3 bits");
   end

   logic [WIDTH-1:0] logic_y;
   logic [WIDTH-1:0] arith_y;
   logic [WIDTH-1:0] alu_y;
   logic             is_arith;

   // code bit 2 splits logic from arithmetic; within arithmetic,
   // bit 1 selects subtraction and bit 0 selects B over the constant one
   assign is_arith = alu_code_i[2];

   mcalu_logic #(
      .WIDTH (WIDTH)
   ) u_logic (
      .a_i   (opa_i),
      .b_i   (opb_i),
      .sel_i (alu_code_i[1:0]),
      .y_o   (logic_y)
   );

   mcalu_arith #(
      .WIDTH        (WIDTH),
      .RIPPLE_ADDER (RIPPLE_ADDER)
   ) u_arith (
      .a_i      (opa_i),
      .b_i      (opb_i),
      .use_b_i  (alu_code_i[0]),
      .negate_i (alu_code_i[1]),
      .y_o      (arith_y)
   );

   assign alu_y = is_arith ? arith_y : logic_y;

   mcalu_shift #(
      .WIDTH (WIDTH)
   ) u_shift (
      .x_i    (alu_y),
      .code_i (shf_code_i),
      .y_o    (result_o)
   );

   assign zero_o = ~|result_o;

   always_comb begin
      AST_ZERO_FLAG: assert (zero_o == ($countones(result_o) == 0)); // R9
   end
endmodule

// File: tb/mcalu_top_tb.sv
module mcalu_top_tb;
   localparam int W = 8;

   typedef struct {
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic [2:0]   alu;
      logic [2:0]   shf;
      logic [W-1:0] exp_res;
      logic         exp_zero;
   } item_t;

   logic         clk = 1'b0;
   logic [W-1:0] opa = '0;
   logic [W-1:0] opb = '0;
   logic [2:0]   alu_code = '0;
   logic [2:0]   shf_code = '0;
   logic [W-1:0] result;
   logic         zero;

   item_t sb_q[$];
   int    checks = 0;
   int    errors = 0;
   bit    driving_done = 1'b0;

   always #2.5 clk = ~clk;

   mcalu_top #(.WIDTH(W)) u_dut (
      .opa_i      (opa),
      .opb_i      (opb),
      .alu_code_i (alu_code),
      .shf_code_i (shf_code),
      .result_o   (result),
      .zero_o     (zero)
   );

   function automatic logic [W-1:0] ref_alu(input logic [2:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
      int unsigned t;
      case (c)
         3'b000: return ~a;
         3'b001: return a & b;
         3'b010: return a ^ b;
         3'b011: return a | b;
         3'b100: begin t = (int'(a) + 1) % 256; return t[W-1:0]; end
         3'b101: begin t = (int'(a) + int'(b)) % 256; return t[W-1:0]; end
         3'b110: begin t = (int'(a) + 255) % 256; return t[W-1:0]; end
         default: begin t = (int'(a) + 256 - int'(b)) % 256; return t[W-1:0]; end
      endcase
   endfunction

   function automatic logic [W-1:0] ref_shf(input logic [2:0] c, input logic [W-1:0] x);
      case (c)
         3'b001: return {x[6:0], x[7]};
         3'b010: return {x[6:0], 1'b0};
         3'b011: return {x[6:0], 1'b1};
         3'b101: return {x[0], x[7:1]};
         3'b110: return {1'b0, x[7:1]};
         3'b111: return {1'b1, x[7:1]};
         default: return x;
      endcase
   endfunction

   function automatic string alu_req(input logic [2:0] c);
      case (c)
         3'b000: return "R1";
         3'b001, 3'b010, 3'b011: return "R2";
         3'b100, 3'b110: return "R3";
         default: return "R4";
      endcase
   endfunction

   function automatic string shf_req(input logic [2:0] c);
      case (c)
         3'b000, 3'b100: return "R5";
         3'b001, 3'b101: return "R6";
         3'b010, 3'b011: return "R7";
         default: return "R8";
      endcase
   endfunction

   // driver: change inputs just after a rising edge, queue the expectation
   task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [2:0] ac, input logic [2:0] sc);
      item_t it;
      @(posedge clk);
      #1;
      opa = a; opb = b; alu_code = ac; shf_code = sc;
      it.a = a; it.b = b; it.alu = ac; it.shf = sc;
      it.exp_res  = ref_shf(sc, ref_alu(ac, a, b));
      it.exp_zero = (it.exp_res == '0);
      sb_q.push_back(it);
   endtask

   // monitor: zero-cycle latency, compare on the falling edge of the same cycle
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (result !== it.exp_res) begin
               errors++;
               $display("FAIL %s/%s alu=%b shf=%b a=%h b=%h result actual=%h expected=%h",
                        alu_req(it.alu), shf_req(it.shf), it.alu, it.shf, it.a, it.b,
                        result, it.exp_res);
            end
            checks++;
            if (zero !== it.exp_zero) begin
               errors++;
               $display("FAIL R9 alu=%b shf=%b a=%h b=%h zero actual=%b expected=%b",
                        it.alu, it.shf, it.a, it.b, zero, it.exp_zero);
            end
         end
      end
   end

   initial begin
      #(5.0 * 50000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] da[8];
      logic [W-1:0] db[8];
      // directed operands: wrap at both ends, all-zero results, alternating bits
      da[0] = 8'h00; db[0] = 8'h00;
      da[1] = 8'hFF; db[1] = 8'h01;
      da[2] = 8'h00; db[2] = 8'h01;
      da[3] = 8'hFF; db[3] = 8'hFF;
      da[4] = 8'h80; db[4] = 8'h7F;
      da[5] = 8'h55; db[5] = 8'hAA;
      da[6] = 8'h01; db[6] = 8'h80;
      da[7] = 8'h7F; db[7] = 8'h81;

      // inputs all zero: R1 inverse of 0 is FF, passed through by R5, flag low (R9)
      drive(8'h00, 8'h00, 3'b000, 3'b000);
      // R3 wrap: FF+1 -> 00, flag high (R9)
      drive(8'hFF, 8'h00, 3'b100, 3'b000);
      // R3 wrap: 00-1 -> FF
      drive(8'h00, 8'h00, 3'b110, 3'b000);
      // R4 wrap: 00-01 -> FF, 80+80 -> 00
      drive(8'h00, 8'h01, 3'b111, 3'b000);
      drive(8'h80, 8'h80, 3'b101, 3'b000);
      // R1 and R3: B must have no effect
      drive(8'h3C, 8'hFF, 3'b000, 3'b000);
      drive(8'h3C, 8'hFF, 3'b100, 3'b000);
      drive(8'h3C, 8'hFF, 3'b110, 3'b000);

      for (int ac = 0; ac < 8; ac++) begin
         for (int sc = 0; sc < 8; sc++) begin
            for (int k = 0; k < 8; k++) begin
               drive(da[k], db[k], 3'(ac), 3'(sc));
            end
            for (int k = 0; k < 6; k++) begin
               drive(8'($urandom), 8'($urandom), 3'(ac), 3'(sc));
            end
         end
      end
      driving_done = 1'b1;
      repeat (3) @(posedge clk);
      checks++;
      if (sb_q.size() != 0) begin
         errors++;
         $display("FAIL R9 scoreboard leftover actual=%0d expected=0", sb_q.size());
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule